// File: doc/BRIEF.md
# Broadcast Shift Register Output Expander

This controller drives a group of 8-bit serial-in, parallel-out output registers that sit side by side on one serial data line and one shift clock, with no chaining between them. A request carries a data byte and a target device number on a valid/ready stream. Every attached device clocks in the same byte. The controller then raises only the target's own latch strobe, so only that device copies the byte into its output stage. The strobe works as an edge-triggered select. A shared active-low output enable follows a plain control input and has no part in device selection.

Back-pressure rules: `in_ready` is high only while the controller is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The requester must hold the byte, the device number and `in_valid` steady until that edge. After a request is taken, `in_ready` stays low through the whole shift and latch sequence. It rises again in the cycle in which the latch strobe has returned low. The shift-clock rate comes from a divider input that is captured when the request is taken.

Top module: `bsx_expander`

## Requirements
- R1: `in_ready` is high only while idle. A request is accepted on an edge with `in_valid` and `in_ready` both high, and `in_ready` is low from the next cycle until every latch strobe is low again. While any strobe is high, `in_ready` is low.
- R2: Each transfer gives exactly 8 rising edges on `ser_clk`, most significant bit first. `ser_dat` changes only in cycles where `ser_clk` is low.
- R3: `ser_clk` idles low. Each high phase and each low phase lasts `div_half`+1 system clocks, using the `div_half` value captured at acceptance. Later changes to `div_half` do not affect a transfer in progress.
- R4: Every device receives the same serial byte on every transfer, whatever the target.
- R5: For an in-range target, only `latch_clk[target]` rises (bit i drives device i). It rises at the final falling edge of `ser_clk` and stays high for 2*(`div_half`+1) system clocks, which is one full shift-clock period. No other device's latched outputs change.
- R6: A target number of `NUM_DEV` or more still shifts the byte. No latch strobe rises, and `idx_err` is high for exactly one cycle after the last bit.
- R7: `oe_n` equals the inverse of `out_en`, registered one cycle later. It has no effect on shifting or latching.
- R8: While `rst` is high, the next edge drives `ser_clk`, `ser_dat` and all `latch_clk` bits low, sets `oe_n` high, and leaves the controller idle with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_half | input | DIV_W | Shift-clock half period minus one, in system clocks |
| out_en | input | 1 | Output enable request, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request ready |
| in_data | input | DATA_W | Byte to broadcast |
| in_dev | input | IDX_W | Target device number |
| ser_clk | output | 1 | Shared shift clock |
| ser_dat | output | 1 | Shared serial data |
| latch_clk | output | NUM_DEV | Per-device latch strobes |
| oe_n | output | 1 | Shared output enable, active low |
| idx_err | output | 1 | One-cycle flag for an out-of-range target |

## Verification
The end of a latch strobe and the acceptance of the next request can fall in the same cycle, because `in_ready` rises on the very edge where the strobe drops. The bench provokes this by holding `in_valid` high through two back-to-back requests to the same device. At the accepting edge it checks that no strobe is still high and that `in_ready` is low at once afterwards. The device model must then show the second byte after two latch rises. A change of `div_half` in the cycle right after acceptance is also judged, by measuring the high-phase width of the shift clock.

// File: rtl/bsx_pkg.sv
`timescale 1ns/1ps
package bsx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } bsx_state_e;
endpackage

// File: rtl/bsx_tick_gen.sv
`timescale 1ns/1ps
module bsx_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bsx_latch_dec.sv
`timescale 1ns/1ps
module bsx_latch_dec #(
  parameter int NUM_DEV = 5,
  parameter int IDX_W   = 3
) (
  input  logic [IDX_W-1:0]   dev_idx,
  output logic [NUM_DEV-1:0] sel,
  output logic               in_range
);
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
    assign sel[i] = (dev_idx == IDX_W'(i));
  end
  assign in_range = ({1'b0, dev_idx} < (IDX_W+1)'(NUM_DEV));
endmodule

// File: rtl/bsx_expander.sv
`timescale 1ns/1ps
module bsx_expander
  import bsx_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_W-1:0]   div_half,
  input  logic               out_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [IDX_W-1:0]   in_dev,
  output logic               ser_clk,
  output logic               ser_dat,
  output logic [NUM_DEV-1:0] latch_clk,
  output logic               oe_n,
  output logic               idx_err
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  bsx_state_e          state_q;
  logic [DATA_W-1:0]   shreg_q;
  logic [CNT_W-1:0]    bitcnt_q;
  logic [DIV_W-1:0]    div_q;
  logic [IDX_W-1:0]    dev_q;
  logic                sclk_q, sdat_q, err_q, oen_q, lphase_q;
  logic [NUM_DEV-1:0]  latch_q;
  logic                tick, dev_ok;
  logic [NUM_DEV-1:0]  dec_sel;

  bsx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .run   (state_q != ST_IDLE),
    .limit (div_q),
    .tick  (tick)
  );

  bsx_latch_dec #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_dec (
    .dev_idx  (dev_q),
    .sel      (dec_sel),
    .in_range (dev_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      div_q    <= '0;
      dev_q    <= '0;
      sclk_q   <= 1'b0;
      sdat_q   <= 1'b0;
      latch_q  <= '0;
      err_q    <= 1'b0;
      oen_q    <= 1'b1;
      lphase_q <= 1'b0;
    end else begin
      oen_q <= ~out_en;
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            shreg_q  <= in_data << 1;
            sdat_q   <= in_data[DATA_W-1];
            div_q    <= div_half;
            dev_q    <= in_dev;
            bitcnt_q <= '0;
            sclk_q   <= 1'b0;
            state_q  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bitcnt_q == LAST_BIT) begin
                sdat_q <= 1'b0;
                if (dev_ok) begin
                  latch_q  <= dec_sel;
                  lphase_q <= 1'b0;
                  state_q  <= ST_LATCH;
                end else begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
                end
              end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
                sdat_q   <= shreg_q[DATA_W-1];
                shreg_q  <= shreg_q << 1;
              end
            end
          end
        end
        ST_LATCH: begin
          if (tick) begin
            if (!lphase_q) begin
              lphase_q <= 1'b1;
            end else begin
              latch_q <= '0;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign ser_clk   = sclk_q;
  assign ser_dat   = sdat_q;
  assign latch_clk = latch_q;
  assign oe_n      = oen_q;
  assign idx_err   = err_q;
endmodule

// File: rtl/bsx_expander_chk.sv
`timescale 1ns/1ps
module bsx_expander_chk #(
  parameter int NUM_DEV = 5,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [DIV_W-1:0]   div_half,
  input logic               out_en,
  input logic               in_valid,
  input logic               in_ready,
  input logic [DATA_W-1:0]  in_data,
  input logic [IDX_W-1:0]   in_dev,
  input logic               ser_clk,
  input logic               ser_dat,
  input logic [NUM_DEV-1:0] latch_clk,
  input logic               oe_n,
  input logic               idx_err
);
  assert_latch_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (|latch_clk) |-> !in_ready);

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_data_low_phase_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_dat) |-> !ser_clk);

  assert_one_latch_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(latch_clk));

  assert_latch_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(|latch_clk) |-> (!ser_clk && $fell(ser_clk)));

  assert_err_no_latch_R6: assert property (@(posedge clk) disable iff (rst)
    idx_err |-> (latch_clk == '0));

  assert_oe_follow_R7: assert property (@(posedge clk) disable iff (rst)
    out_en |=> !oe_n);

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (oe_n && !ser_clk && !ser_dat && (latch_clk == '0) && in_ready));
endmodule

bind bsx_expander bsx_expander_chk #(
  .NUM_DEV(NUM_DEV), .DATA_W(DATA_W), .DIV_W(DIV_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/bsx_expander_tb.sv
`timescale 1ns/1ps
module bsx_dev_model (
  input  logic       sck,
  input  logic       sdi,
  input  logic       lck,
  input  logic       oe_n,
  output logic [7:0] sr,
  output logic [7:0] q,
  output logic       hz
);
  always @(posedge sck) sr <= {sr[6:0], sdi};
  always @(posedge lck) q <= sr;
  assign hz = oe_n;
endmodule

module bsx_expander_tb;
  localparam int NUM_DEV = 5;
  localparam int IDX_W   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] div_half = 8'd1;
  logic out_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic [IDX_W-1:0] in_dev = '0;
  logic ser_clk, ser_dat, oe_n, idx_err;
  logic [NUM_DEV-1:0] latch_clk;

  always #2.5 clk = ~clk;

  bsx_expander u_dut (
    .clk(clk), .rst(rst), .div_half(div_half), .out_en(out_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_dev(in_dev),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .latch_clk(latch_clk),
    .oe_n(oe_n), .idx_err(idx_err)
  );

  logic [7:0] m_sr [NUM_DEV];
  logic [7:0] m_q  [NUM_DEV];
  logic       m_hz [NUM_DEV];
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    bsx_dev_model u_m (.sck(ser_clk), .sdi(ser_dat), .lck(latch_clk[g]),
                       .oe_n(oe_n), .sr(m_sr[g]), .q(m_q[g]), .hz(m_hz[g]));
  end

  // monitors, written only here
  int rises, hi_run, last_hi, errs, viol, cyc;
  int l_rise [NUM_DEV];
  int l_hi   [NUM_DEV];
  logic p_clk, p_dat;
  logic [NUM_DEV-1:0] p_lat;
  initial begin
    rises = 0; hi_run = 0; last_hi = 0; errs = 0; viol = 0;
    p_clk = 0; p_dat = 0; p_lat = '0;
    for (int i = 0; i < NUM_DEV; i++) begin l_rise[i] = 0; l_hi[i] = 0; end
  end
  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk && !p_clk) rises++;
      if (ser_clk) hi_run++;
      else if (p_clk) begin last_hi = hi_run; hi_run = 0; end
      if (ser_dat != p_dat && ser_clk) viol++;
      if (idx_err) errs++;
      for (int i = 0; i < NUM_DEV; i++) begin
        if (latch_clk[i]) l_hi[i]++;
        if (latch_clk[i] && !p_lat[i]) l_rise[i]++;
      end
    end
    p_clk = ser_clk; p_dat = ser_dat; p_lat = latch_clk;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        n_fail++; n_chk++;
        $display("FAIL R1: watchdog expired, actual %0d expected 0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  task automatic send(input logic [7:0] d, input int dev, input logic [7:0] dv);
    @(negedge clk);
    in_data = d; in_dev = IDX_W'(dev); div_half = dv; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    chk(latch_clk == '0, "R1 accept with strobes low", int'(latch_clk), 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R1 ready low after accept", int'(in_ready), 0);
  endtask

  task automatic wait_idle();
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  int b_r, b_e, b_v;
  int b_lr [NUM_DEV];
  int b_lh [NUM_DEV];
  task automatic snap();
    b_r = rises; b_e = errs; b_v = viol;
    for (int i = 0; i < NUM_DEV; i++) begin b_lr[i] = l_rise[i]; b_lh[i] = l_hi[i]; end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!ser_clk && !ser_dat, "R8 serial lines low", int'({ser_clk, ser_dat}), 0);
    chk(latch_clk == '0, "R8 strobes low", int'(latch_clk), 0);
    chk(oe_n, "R8 oe_n high", int'(oe_n), 1);
    chk(in_ready, "R8 ready high", int'(in_ready), 1);
    rst = 1'b0;
  endtask

  task automatic t_basic();
    out_en = 1'b1;
    snap();
    send(8'hA5, 0, 8'd1);
    wait_idle();
    chk(m_q[0] == 8'hA5, "R2 msb-first byte on dev0", m_q[0], 8'hA5);
    chk(rises - b_r == 8, "R2 eight shift edges", rises - b_r, 8);
    chk(viol == b_v, "R2 data change while clock high", viol - b_v, 0);
    chk(last_hi == 2, "R3 high phase width", last_hi, 2);
    chk(l_hi[0] - b_lh[0] == 4, "R5 strobe width", l_hi[0] - b_lh[0], 4);
    for (int i = 0; i < NUM_DEV; i++)
      chk(m_sr[i] == 8'hA5, "R4 broadcast shift content", m_sr[i], 8'hA5);
    for (int i = 1; i < NUM_DEV; i++)
      chk(l_rise[i] == b_lr[i], "R5 unselected strobe quiet", l_rise[i] - b_lr[i], 0);
    chk(!oe_n && !m_hz[0], "R7 outputs driven", int'(oe_n), 0);
  endtask

  task automatic t_select();
    snap();
    send(8'h3C, 2, 8'd0);
    wait_idle();
    chk(m_q[2] == 8'h3C, "R5 dev2 latched", m_q[2], 8'h3C);
    chk(m_q[0] == 8'hA5, "R5 dev0 unchanged", m_q[0], 8'hA5);
    chk(l_hi[2] - b_lh[2] == 2, "R5 strobe width div0", l_hi[2] - b_lh[2], 2);
    chk(last_hi == 1, "R3 high phase div0", last_hi, 1);
    chk(m_sr[4] == 8'h3C, "R4 dev4 shifted too", m_sr[4], 8'h3C);
  endtask

  task automatic t_badidx();
    int lr;
    snap();
    send(8'hFF, 6, 8'd2);
    wait_idle();
    lr = 0;
    for (int i = 0; i < NUM_DEV; i++) lr += l_rise[i] - b_lr[i];
    chk(lr == 0, "R6 no strobe for bad index", lr, 0);
    chk(errs - b_e == 1, "R6 error one cycle", errs - b_e, 1);
    chk(rises - b_r == 8, "R6 byte still shifted", rises - b_r, 8);
    chk(m_sr[1] == 8'hFF, "R6 shift content", m_sr[1], 8'hFF);
    chk(m_q[2] == 8'h3C && m_q[0] == 8'hA5, "R6 outputs unchanged", m_q[2], 8'h3C);
    chk(last_hi == 3, "R3 high phase div2", last_hi, 3);
  endtask

  task automatic t_divhold();
    send(8'h81, 4, 8'd3);
    div_half = 8'd0;
    wait_idle();
    chk(last_hi == 4, "R3 divider captured at accept", last_hi, 4);
    chk(m_q[4] == 8'h81, "R5 dev4 latched", m_q[4], 8'h81);
  endtask

  task automatic t_oe();
    @(negedge clk);
    out_en = 1'b0;
    @(negedge clk);
    chk(oe_n && m_hz[1], "R7 oe_n follows after one edge", int'(oe_n), 1);
    send(8'h5A, 1, 8'd1);
    wait_idle();
    chk(m_q[1] == 8'h5A, "R7 latch works while disabled", m_q[1], 8'h5A);
    out_en = 1'b1;
    @(negedge clk);
    chk(!oe_n, "R7 re-enabled", int'(oe_n), 0);
  endtask

  task automatic t_b2b();
    snap();
    send(8'h11, 3, 8'd1);
    send(8'h22, 3, 8'd1);
    wait_idle();
    chk(m_q[3] == 8'h22, "R1 second byte latched", m_q[3], 8'h22);
    chk(l_rise[3] - b_lr[3] == 2, "R5 two strobes", l_rise[3] - b_lr[3], 2);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_select();
    t_badidx();
    t_divhold();
    t_oe();
    t_b2b();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule